// File: doc/BRIEF.md
# SDR SDRAM Initialization and Single-Word Access Controller

This controller sits between a simple host port and one four-bank, 16-bit SDR SDRAM. Out of reset it holds the clock-enable low. It then raises clock-enable and sends no-operation commands for a programmable power-up wait. Next comes the start-up sequence: it closes every bank, sends a run of refresh commands and programs the operating mode of the memory. From then on it carries out single-word reads and writes for the host and inserts an auto-refresh at a fixed interval. Every access opens a row, issues one column command with auto-precharge, and waits until the bank can accept a new activate.

The host holds `req_valid` together with the address, write flag, data and byte masks until it sees a one-cycle `req_ack`. The request address is split from the top down into bank, row and column. Read data comes back on `rd_data` with a one-cycle `rd_valid` strobe. All timing limits are clock-cycle parameters sized for a 7.5 ns clock. The power-up wait and the refresh interval are parameters too, so a simulation can shorten them.

The state machine has these states:
- `ST_POWERUP`: waits out the power-up time.
- `ST_INIT_PRE`: sends precharge-all.
- `ST_INIT_REF`: sends one start-up refresh; it is entered once per start-up refresh.
- `ST_INIT_MRS`: sends the mode register set.
- `ST_IDLE`: picks the next job. A pending refresh goes to `ST_REFRESH`. Otherwise a host request goes to `ST_ACTIVATE`.
- `ST_REFRESH`: sends a run-time refresh.
- `ST_ACTIVATE`: opens the row.
- `ST_READ` or `ST_WRITE`: sends the column command. `ST_ACTIVATE` goes to one of the two according to `req_write`.
- `ST_WAIT`: every command state passes through here. It counts the required gap and then moves to the state stored on entry.

Top module: `sdram_ctl`

## Requirements
- R1: While `rst_n` is low, `sd_cke` is 0, `sd_cs_n` is 1 (deselect), `sd_dqm` is 2'b11, and `req_ack` and `rd_valid` are 0.
- R2: After reset, `sd_cke` rises and only NOP commands appear for at least INIT_WAIT cycles. The first real command is a precharge with `sd_addr[10]`=1 (all banks). It is followed by exactly INIT_REFRESHES (8) refresh commands and then one mode register set.
- R3: During start-up, precharge to first refresh is at least T_RP (2) cycles, and refresh to refresh and last refresh to mode set are each at least T_RC (7) cycles. Mode set to the first activate is at least T_MRD (2) cycles.
- R4: Commands are encoded as {cs_n,ras_n,cas_n,we_n}: mode set 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, NOP 0111. The mode word on `sd_addr` is 12'h030 (CAS latency 3 in bits 6:4, burst length 1 as 000 in bits 2:0).
- R5: A write sends an activate with bank `req_addr[21:20]` and row `req_addr[19:8]`. Exactly T_RCD (2) cycles later it sends a write carrying the same bank, column `req_addr[7:0]` on `sd_addr[7:0]`, `sd_addr[10]`=1 and `req_wdata` driven on `sd_dq`. `req_ack` is high for exactly one cycle, the cycle in which that write command is on the pins.
- R6: A read sends an activate and, T_RCD cycles later, a read with `sd_addr[10]`=1 while the controller leaves `sd_dq` undriven, acknowledged as in R5. The word the memory returns CAS_LAT cycles after it samples the read appears on `rd_data`, with `rd_valid` high for one cycle, 4 cycles after the read command is first on the pins.
- R7: Two activates are at least T_RC (7) cycles apart. An activate or refresh follows a write command by at least T_DAL (4) cycles.
- R8: After start-up a refresh falls due every REF_INTERVAL cycles, and a due refresh is served before any waiting host request. A refresh is sent only at least T_RC cycles after the last activate. With no host traffic, refreshes are exactly REF_INTERVAL cycles apart.
- R9: On a write, `sd_dqm` equals `req_wmask`: bit 0 masks `sd_dq[7:0]` and bit 1 masks `sd_dq[15:8]`, so masked bytes keep their old memory content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also forwarded to the memory |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | {bank[1:0], row[11:0], column[7:0]} |
| req_wdata | input | 16 | Write data |
| req_wmask | input | 2 | Write byte masks, 1 = byte not written |
| req_ack | output | 1 | One-cycle request acknowledge |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Read data |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Row / column / mode address |
| sd_dqm | output | 2 | Byte masks |
| sd_dq | inout | 16 | Bidirectional data |

## Verification
The bench attaches a behavioural memory that honours byte masks and returns read data three clocks after sampling a read. A capture one cycle off in the read pipeline therefore shows up as a wrong `rd_data` or a shifted `rd_valid`. It checks the start-up command order and gaps, so a design that skips or miscounts start-up refreshes, or programs the wrong mode word, is caught. Partial and full byte masks are applied and read back; swapped mask bits leave the wrong byte intact. Refresh spacing is measured both idle and under continuous writes. A design that lets host traffic starve refresh, or miscounts the interval, produces a gap that is too large or not exact.

// File: rtl/sdram_ctl_pkg.sv
package sdram_ctl_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS   = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_ACT   = 4'b0011,
        CMD_WR    = 4'b0100,
        CMD_RD    = 4'b0101,
        CMD_NOP   = 4'b0111,
        CMD_DESEL = 4'b1111
    } sd_cmd_e;

    typedef enum logic [3:0] {
        ST_POWERUP,
        ST_INIT_PRE,
        ST_INIT_REF,
        ST_INIT_MRS,
        ST_IDLE,
        ST_REFRESH,
        ST_ACTIVATE,
        ST_READ,
        ST_WRITE,
        ST_WAIT
    } ctl_state_e;

endpackage

// File: rtl/sdram_ctl_timer.sv
module sdram_ctl_timer #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= W'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) == '0 && !$past(load)) |-> cnt_q == '0); // R3
endmodule

// File: rtl/sdram_ctl_refresh.sv
module sdram_ctl_refresh #(
    parameter int unsigned INTERVAL = 2080
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic clear,
    output logic pending
);
    localparam int unsigned RW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    logic [RW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pending <= 1'b0;
        end else begin
            if (clear)
                pending <= 1'b0;
            if (enable) begin
                if (cnt_q == RW'(INTERVAL - 1)) begin
                    cnt_q   <= '0;
                    pending <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_REF_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(enable)); // R8
endmodule

// File: rtl/sdram_ctl.sv
module sdram_ctl
    import sdram_ctl_pkg::*;
#(
    parameter int unsigned INIT_WAIT      = 26667,
    parameter int unsigned REF_INTERVAL   = 2080,
    parameter int unsigned INIT_REFRESHES = 8,
    parameter int unsigned T_RP           = 2,
    parameter int unsigned T_RCD          = 2,
    parameter int unsigned T_RC           = 7,
    parameter int unsigned T_MRD          = 2,
    parameter int unsigned T_DAL          = 4,
    parameter int unsigned CAS_LAT        = 3,
    parameter int unsigned BANK_W         = 2,
    parameter int unsigned ROW_W          = 12,
    parameter int unsigned COL_W          = 8,
    parameter int unsigned DQ_W           = 16,
    parameter int unsigned DM_W           = DQ_W / 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [BANK_W+ROW_W+COL_W-1:0]  req_addr,
    input  logic [DQ_W-1:0]                req_wdata,
    input  logic [DM_W-1:0]                req_wmask,
    output logic                           req_ack,
    output logic                           rd_valid,
    output logic [DQ_W-1:0]                rd_data,
    output logic                           sd_cke,
    output logic                           sd_cs_n,
    output logic                           sd_ras_n,
    output logic                           sd_cas_n,
    output logic                           sd_we_n,
    output logic [BANK_W-1:0]              sd_ba,
    output logic [ROW_W-1:0]               sd_addr,
    output logic [DM_W-1:0]                sd_dqm,
    inout  wire  [DQ_W-1:0]                sd_dq
);
    localparam int unsigned TW0    = $clog2(INIT_WAIT + 1);
    localparam int unsigned TW     = (TW0 < 4) ? 4 : TW0;
    localparam int unsigned IRW    = $clog2(INIT_REFRESHES + 1);
    localparam int unsigned RD_GAP = T_RC - T_RCD;
    localparam int unsigned WR_GAP = (T_DAL > RD_GAP) ? T_DAL : RD_GAP;
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'({3'(CAS_LAT), 4'b0000});

    ctl_state_e st_q, st_d, ret_q, ret_d;
    logic [IRW-1:0] iref_q, iref_d;
    logic           tmr_load, tmr_done, ref_pend, ref_clr, init_done_q;
    logic [TW-1:0]  tmr_val;

    logic [BANK_W-1:0] req_bank;
    logic [ROW_W-1:0]  req_row;
    logic [COL_W-1:0]  req_col;
    assign {req_bank, req_row, req_col} = req_addr;

    sdram_ctl_timer #(.W(TW), .RST_VAL(INIT_WAIT - 1)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    sdram_ctl_refresh #(.INTERVAL(REF_INTERVAL)) u_refresh (
        .clk(clk), .rst_n(rst_n), .enable(init_done_q), .clear(ref_clr), .pending(ref_pend)
    );

    // next-state logic
    always_comb begin
        st_d     = st_q;
        ret_d    = ret_q;
        iref_d   = iref_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ref_clr  = 1'b0;
        unique case (st_q)
            ST_POWERUP:  if (tmr_done) st_d = ST_INIT_PRE;
            ST_INIT_PRE: begin
                tmr_load = 1'b1; tmr_val = TW'(T_RP - 2);
                ret_d = ST_INIT_REF; st_d = ST_WAIT;
            end
            ST_INIT_REF: begin
                tmr_load = 1'b1; tmr_val = TW'(T_RC - 2);
                iref_d = iref_q + 1'b1;
                ret_d = (iref_q == IRW'(INIT_REFRESHES - 1)) ? ST_INIT_MRS : ST_INIT_REF;
                st_d = ST_WAIT;
            end
            ST_INIT_MRS: begin
                tmr_load = 1'b1; tmr_val = TW'(T_MRD - 2);
                ret_d = ST_IDLE; st_d = ST_WAIT;
            end
            ST_IDLE: begin
                if (ref_pend)       st_d = ST_REFRESH;
                else if (req_valid) st_d = ST_ACTIVATE;
            end
            ST_REFRESH: begin
                tmr_load = 1'b1; tmr_val = TW'(T_RC - 2); ref_clr = 1'b1;
                ret_d = ST_IDLE; st_d = ST_WAIT;
            end
            ST_ACTIVATE: begin
                tmr_load = 1'b1; tmr_val = TW'(T_RCD - 2);
                ret_d = req_write ? ST_WRITE : ST_READ; st_d = ST_WAIT;
            end
            ST_READ: begin
                tmr_load = 1'b1; tmr_val = TW'(RD_GAP - 2);
                ret_d = ST_IDLE; st_d = ST_WAIT;
            end
            ST_WRITE: begin
                tmr_load = 1'b1; tmr_val = TW'(WR_GAP - 2);
                ret_d = ST_IDLE; st_d = ST_WAIT;
            end
            ST_WAIT:     if (tmr_done) st_d = ret_q;
            default:     st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_POWERUP;
            ret_q       <= ST_IDLE;
            iref_q      <= '0;
            init_done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ret_q  <= ret_d;
            iref_q <= iref_d;
            if (st_q == ST_IDLE) init_done_q <= 1'b1;
        end
    end

    // output decode, registered onto the pins
    sd_cmd_e          cmd_d, cmd_q;
    logic [BANK_W-1:0] ba_d;
    logic [ROW_W-1:0]  a_d;
    logic [DM_W-1:0]   dqm_d;
    logic              oe_d, oe_q, ack_d;
    logic [DQ_W-1:0]   wdat_q;

    always_comb begin
        cmd_d = CMD_NOP;
        ba_d  = '0;
        a_d   = '0;
        dqm_d = '0;
        oe_d  = 1'b0;
        ack_d = 1'b0;
        unique case (st_q)
            ST_INIT_PRE: begin cmd_d = CMD_PRE; a_d[10] = 1'b1; end
            ST_INIT_REF, ST_REFRESH: cmd_d = CMD_REF;
            ST_INIT_MRS: begin cmd_d = CMD_MRS; a_d = MODE_WORD; end
            ST_ACTIVATE: begin cmd_d = CMD_ACT; ba_d = req_bank; a_d = req_row; end
            ST_READ: begin
                cmd_d = CMD_RD; ba_d = req_bank; ack_d = 1'b1;
                a_d[COL_W-1:0] = req_col; a_d[10] = 1'b1;
            end
            ST_WRITE: begin
                cmd_d = CMD_WR; ba_d = req_bank; ack_d = 1'b1;
                a_d[COL_W-1:0] = req_col; a_d[10] = 1'b1;
                dqm_d = req_wmask; oe_d = 1'b1;
            end
            default: cmd_d = CMD_NOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_cke  <= 1'b0;
            cmd_q   <= CMD_DESEL;
            sd_ba   <= '0;
            sd_addr <= '0;
            sd_dqm  <= '1;
            oe_q    <= 1'b0;
            req_ack <= 1'b0;
            wdat_q  <= '0;
        end else begin
            sd_cke  <= 1'b1;
            cmd_q   <= cmd_d;
            sd_ba   <= ba_d;
            sd_addr <= a_d;
            sd_dqm  <= dqm_d;
            oe_q    <= oe_d;
            req_ack <= ack_d;
            wdat_q  <= req_wdata;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_dq = oe_q ? wdat_q : {DQ_W{1'bz}};

    // read return: capture CAS_LAT edges after the memory samples the read
    logic [CAS_LAT:0] rd_pipe_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pipe_q <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            rd_pipe_q <= {rd_pipe_q[CAS_LAT-1:0], st_q == ST_READ};
            rd_valid  <= rd_pipe_q[CAS_LAT];
            if (rd_pipe_q[CAS_LAT]) rd_data <= sd_dq;
        end
    end

    // pin-level spacing counters for the checks below
    logic [3:0] since_act, since_wr, since_mrs;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= 4'hF; since_wr <= 4'hF; since_mrs <= 4'hF;
        end else begin
            since_act <= (cmd_q == CMD_ACT) ? 4'h0 : ((since_act == 4'hF) ? 4'hF : since_act + 1'b1);
            since_wr  <= (cmd_q == CMD_WR)  ? 4'h0 : ((since_wr  == 4'hF) ? 4'hF : since_wr  + 1'b1);
            since_mrs <= (cmd_q == CMD_MRS) ? 4'h0 : ((since_mrs == 4'hF) ? 4'hF : since_mrs + 1'b1);
        end
    end

    AST_COL_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> since_act >= 4'(T_RCD - 1)); // R5
    AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_ACT) |-> since_act >= 4'(T_RC - 1)); // R7
    AST_WRITE_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_ACT || cmd_q == CMD_REF) |-> since_wr >= 4'(T_DAL - 1)); // R7
    AST_REF_BANKS_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_REF) |-> since_act >= 4'(T_RC - 1)); // R8
    AST_MRS_TO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_ACT) |-> since_mrs >= 4'(T_MRD - 1)); // R3
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack); // R5
    AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R6
endmodule

// File: tb/sdram_ctl_test.sv
module sdram_ctl_test;
    localparam int INIT_WAIT = 100;
    localparam int RI        = 300;
    localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                           C_ACT = 4'b0011, C_WR  = 4'b0100, C_RD  = 4'b0101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [21:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_wmask = '0;
    logic        req_ack, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [15:0] rd_data;
    logic [1:0]  sd_ba, sd_dqm;
    logic [11:0] sd_addr;
    wire  [15:0] sd_dq;

    always #5 clk = ~clk;

    sdram_ctl #(.INIT_WAIT(INIT_WAIT), .REF_INTERVAL(RI)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_wmask(req_wmask),
        .req_ack(req_ack), .rd_valid(rd_valid), .rd_data(rd_data),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq(sd_dq)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- memory model (acts between edges) ----------------
    logic [15:0] mem [logic [21:0]];
    logic [11:0] open_row [4];
    logic        mdl_oe = 1'b0;
    logic [15:0] mdl_dq = '0;
    logic [3:0]  rs = '0;
    logic [15:0] rdat [4];
    assign sd_dq = mdl_oe ? mdl_dq : 16'bz;

    always @(negedge clk) begin
        logic [3:0]  c;
        logic [21:0] key;
        logic [15:0] old;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        rs = {rs[2:0], 1'b0};
        rdat[3] = rdat[2]; rdat[2] = rdat[1]; rdat[1] = rdat[0];
        if (rst_n && sd_cke && !sd_cs_n) begin
            key = {sd_ba, open_row[sd_ba], sd_addr[7:0]};
            if (c == C_ACT) open_row[sd_ba] = sd_addr;
            if (c == C_WR) begin
                old = mem.exists(key) ? mem[key] : 16'h0000;
                mem[key] = {sd_dqm[1] ? old[15:8] : sd_dq[15:8],
                            sd_dqm[0] ? old[7:0]  : sd_dq[7:0]};
            end
            if (c == C_RD) begin
                rs[0] = 1'b1;
                rdat[0] = mem.exists(key) ? mem[key] : 16'h0000;
            end
        end
        mdl_oe = rs[3];
        mdl_dq = rdat[3];
    end

    // ---------------- pin monitor ----------------
    int          cyc = 0, ncmd = 0, nref = 0, rel_cyc = 0;
    int          last_act = -100, last_wr = -100, last_mrs = -100, last_ref = -1;
    int          last_rd = -100, ref_gap = 0, max_gap = 0;
    logic [3:0]  log_cmd [10];
    logic [11:0] log_a   [10];
    int          log_cyc [10];
    logic [1:0]  act_ba;
    logic [11:0] act_row;
    bit          got_rd = 0;
    logic [15:0] got_data;

    always @(negedge clk) begin
        logic [3:0] c;
        cyc++;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (rst_n && !sd_cs_n && c != 4'b0111) begin
            if (ncmd < 10) begin
                log_cmd[ncmd] = c; log_a[ncmd] = sd_addr; log_cyc[ncmd] = cyc;
            end
            ncmd++;
            case (c)
                C_ACT: begin
                    chk(cyc - last_act >= 7, "R7 act-to-act gap", cyc - last_act, 7);
                    chk(cyc - last_wr >= 4, "R7 write-to-act gap", cyc - last_wr, 4);
                    chk(cyc - last_mrs >= 2, "R3 mode-set-to-act gap", cyc - last_mrs, 2);
                    chk({sd_ba, sd_addr} == req_addr[21:8], "R5 act bank/row",
                        {sd_ba, sd_addr}, req_addr[21:8]);
                    last_act = cyc; act_ba = sd_ba; act_row = sd_addr;
                end
                C_WR, C_RD: begin
                    chk(cyc - last_act == 2, "R5 R6 act-to-column gap", cyc - last_act, 2);
                    chk(sd_addr[10] == 1'b1, "R5 R6 auto-precharge bit", sd_addr[10], 1);
                    chk({sd_ba, sd_addr[7:0]} == {req_addr[21:20], req_addr[7:0]},
                        "R5 R6 bank/column", {sd_ba, sd_addr[7:0]}, {req_addr[21:20], req_addr[7:0]});
                    if (c == C_WR) begin
                        chk(sd_dq == req_wdata, "R5 write data", sd_dq, req_wdata);
                        chk(sd_dqm == req_wmask, "R9 write masks", sd_dqm, req_wmask);
                        last_wr = cyc;
                    end else begin
                        last_rd = cyc;
                    end
                    chk(req_ack == 1'b1, "R5 ack with column command", req_ack, 1);
                end
                C_REF: begin
                    chk(cyc - last_act >= 7, "R8 refresh with banks closed", cyc - last_act, 7);
                    if (ncmd > 10) begin
                        if (last_ref > 0) begin
                            ref_gap = cyc - last_ref;
                            if (ref_gap > max_gap) max_gap = ref_gap;
                        end
                        last_ref = cyc;
                        nref++;
                    end
                end
                C_MRS: last_mrs = cyc;
                default: ;
            endcase
        end
        if (rst_n && rd_valid) begin
            chk(cyc - last_rd == 4, "R6 read return latency", cyc - last_rd, 4);
            got_data = rd_data;
            got_rd = 1'b1;
        end
    end

    // ---------------- host side ----------------
    task automatic host_op(input logic wr, input logic [21:0] a, input logic [15:0] d,
                           input logic [1:0] m, input logic [15:0] exp);
        bit seen;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_wmask = m;
        seen = 0;
        for (int i = 0; i < 400 && !seen; i++) begin
            @(negedge clk);
            if (req_ack) seen = 1;
        end
        req_valid = 1'b0;
        got_rd = 1'b0;
        chk(seen, "R5 R6 request acknowledged", seen, 1);
        @(negedge clk);
        chk(req_ack == 1'b0, "R5 ack lasts one cycle", req_ack, 0);
        if (!wr) begin
            for (int i = 0; i < 20 && !got_rd; i++) @(negedge clk);
            chk(got_rd, "R6 read data returned", got_rd, 1);
            chk(got_data == exp, "R6 R9 read data value", got_data, exp);
        end
    endtask

    // {write, bank, row, col, data, mask, expected read}
    localparam logic [56:0] VEC [10] = '{
        {1'b1, 2'd0, 12'h005, 8'h10, 16'hA1B2, 2'b00, 16'h0000},
        {1'b1, 2'd3, 12'hFFF, 8'hFF, 16'h1234, 2'b00, 16'h0000},
        {1'b0, 2'd0, 12'h005, 8'h10, 16'h0000, 2'b00, 16'hA1B2},
        {1'b1, 2'd0, 12'h005, 8'h10, 16'hFFFF, 2'b01, 16'h0000},
        {1'b0, 2'd0, 12'h005, 8'h10, 16'h0000, 2'b00, 16'hFFB2},
        {1'b0, 2'd3, 12'hFFF, 8'hFF, 16'h0000, 2'b00, 16'h1234},
        {1'b1, 2'd2, 12'h800, 8'h00, 16'h5A5A, 2'b10, 16'h0000},
        {1'b0, 2'd2, 12'h800, 8'h00, 16'h0000, 2'b00, 16'h005A},
        {1'b1, 2'd1, 12'h001, 8'h80, 16'hC3C3, 2'b11, 16'h0000},
        {1'b0, 2'd1, 12'h001, 8'h80, 16'h0000, 2'b00, 16'h0000}
    };

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int n0;
        repeat (4) @(negedge clk);
        chk(sd_cke == 1'b0, "R1 cke low in reset", sd_cke, 0);
        chk(sd_cs_n == 1'b1, "R1 deselected in reset", sd_cs_n, 1);
        chk(sd_dqm == 2'b11, "R1 masks high in reset", sd_dqm, 3);
        chk(req_ack == 1'b0 && rd_valid == 1'b0, "R1 strobes low in reset", {req_ack, rd_valid}, 0);
        rst_n = 1'b1; rel_cyc = cyc;
        repeat (10) @(negedge clk);
        chk(sd_cke == 1'b1, "R2 cke high after reset", sd_cke, 1);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R2 NOP during wait",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);

        for (int i = 0; i < 400 && ncmd < 10; i++) @(negedge clk);
        chk(ncmd == 10, "R2 start-up command count", ncmd, 10);
        chk(log_cyc[0] - rel_cyc >= INIT_WAIT, "R2 power-up wait", log_cyc[0] - rel_cyc, INIT_WAIT);
        chk(log_cmd[0] == C_PRE, "R2 R4 first command precharge", log_cmd[0], C_PRE);
        chk(log_a[0][10] == 1'b1, "R2 precharge all banks", log_a[0][10], 1);
        chk(log_cyc[1] - log_cyc[0] >= 2, "R3 precharge-to-refresh", log_cyc[1] - log_cyc[0], 2);
        for (int i = 1; i <= 8; i++) begin
            chk(log_cmd[i] == C_REF, "R2 R4 start-up refresh", log_cmd[i], C_REF);
            chk(log_cyc[i+1] - log_cyc[i] >= 7, "R3 refresh spacing", log_cyc[i+1] - log_cyc[i], 7);
        end
        chk(log_cmd[9] == C_MRS, "R2 R4 mode set last", log_cmd[9], C_MRS);
        chk(log_a[9] == 12'h030, "R4 mode word", log_a[9], 12'h030);

        foreach (VEC[i]) begin
            host_op(VEC[i][56], VEC[i][55:34], VEC[i][33:18], VEC[i][17:16], VEC[i][15:0]);
        end

        // idle: refresh spacing must be exact
        repeat (3 * RI + 20) @(negedge clk);
        chk(nref >= 3, "R8 idle refreshes occur", nref, 3);
        chk(ref_gap == RI, "R8 idle refresh interval", ref_gap, RI);
        n0 = nref;
        max_gap = 0;

        // continuous host writes: refresh must still win
        for (int i = 0; i < 3 * RI / 7; i++) begin
            host_op(1'b1, {2'd1, 12'h002, 8'(i)}, 16'(i * 3), 2'b00, 16'h0000);
        end
        chk(nref - n0 >= 2, "R8 refresh under load", nref - n0, 2);
        chk(max_gap <= RI + 10, "R8 refresh priority over host", max_gap, RI + 10);
        host_op(1'b0, {2'd1, 12'h002, 8'd5}, 16'h0000, 2'b00, 16'd15);

        finish_run();
    end
endmodule